// File: doc/BRIEF.md
# SCL Period Generator

This block times the two phases of the serial clock for an I2C byte engine. One configuration word carries two counts in system clock cycles: the whole SCL period and, on its own, the length of the low phase. The high phase gets whatever remains of the period. Because the low count is set independently, software can choose a duty cycle (for example, low at 5/9 of the period) that meets the minimum low and high times of both 100 kHz and 400 kHz operation. Software still works out the period itself, as system clock rate divided by bus rate.

Once the controller leaves its reset, the generator pulls SCL low for the programmed low count and then releases it. The high phase is counted only from the first cycle in which the sampled SCL line actually reads high, so a slave that stretches the clock lengthens the high phase. Two single-cycle strobes tell the byte engine when to act. One falls in the middle of the low phase, where SDA may change. The other falls on the first high cycle, where SDA is sampled. The configuration word is captured at the start of every period, so a write made mid-period takes effect cleanly at the next period.

Top module: `scl_period_gen`

## Requirements
- R1: The period count is `cfg_i[15:0]` and the low count is `cfg_i[31:16]`. The high count is the period minus the low count.
- R2: While `rst_n` is low or `ctl_rst_i` is high, `scl_low_o`, `chg_stb_o` and `smp_stb_o` are all 0 from the clock after `ctl_rst_i` is sampled high. The phase counter restarts from zero. This holds even when the controller reset arrives in the middle of a phase.
- R3: On the first clock edge at which `ctl_rst_i` is sampled low, `scl_low_o` goes to 1. It stays at 1 for exactly the effective low count in cycles.
- R4: After the low phase, `scl_low_o` is 0 for the effective high count in cycles, provided SCL reads high. The pattern then repeats, with an overall period equal to low count plus high count.
- R5: When SCL is released but `scl_in_i` reads 0 (stretching), `scl_low_o` stays 0, no strobe is raised, and the high count does not advance until `scl_in_i` reads 1.
- R6: `chg_stb_o` is a one-cycle pulse at offset floor(L/2) from the first low cycle of each period, where L is the effective low count.
- R7: `smp_stb_o` is a one-cycle pulse in the first high-phase cycle in which `scl_in_i` reads 1.
- R8: The configuration is captured when each low phase begins. A change to `cfg_i` during a period alters only the following periods.
- R9: A low count of 0 is treated as 1. If the period is not greater than the effective low count, the high count is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_rst_i | input | 1 | Controller held in reset; holds the generator idle |
| cfg_i | input | 32 | Low count in upper half, period count in lower half |
| scl_in_i | input | 1 | Synchronized level of the SCL line |
| scl_low_o | output | 1 | 1 = pull SCL low, 0 = release SCL |
| chg_stb_o | output | 1 | SDA change strobe, mid low phase |
| smp_stb_o | output | 1 | SDA sample strobe, first high cycle |

## Verification
The assertions take `scl_in_i` to be already synchronized to `clk`. They also take `ctl_rst_i` to be synchronous, and they accept any `cfg_i` value at any time, because the block latches it itself. The stimulus models the wire as released-and-not-stretched, combinationally from `scl_low_o`, and adds a stretch term that the bench raises only while SCL is released or already low. Configuration changes are applied both while the controller is in reset and in the middle of a running period.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode #(
  parameter int CNT_W = 16
) (
  input  logic [2*CNT_W-1:0] cfg_i,
  output logic [CNT_W-1:0]   lo_len_o,
  output logic [CNT_W-1:0]   hi_len_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] per_f;
  logic [CNT_W-1:0] low_f;

  // Split the word, then clamp both lengths to at least one cycle.
  always_comb begin
    per_f    = cfg_i[CNT_W-1:0];
    low_f    = cfg_i[2*CNT_W-1:CNT_W];
    lo_len_o = (low_f == '0) ? ONE : low_f;
    hi_len_o = (per_f > lo_len_o) ? (per_f - lo_len_o) : ONE;
  end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_rst_i,
  input  logic             scl_in_i,
  input  logic [CNT_W-1:0] lo_len_i,
  input  logic [CNT_W-1:0] hi_len_i,
  output scl_phase_e       phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lo_q_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  scl_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lo_q, hi_q;
  logic             cfg_ld;

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cfg_ld  = 1'b0;
    if (ctl_rst_i) begin
      phase_d = PH_OFF;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_OFF: begin
          phase_d = PH_LOW;
          cnt_d   = '0;
          cfg_ld  = 1'b1;
        end
        PH_LOW: begin
          if (cnt_q == lo_q - ONE) begin
            phase_d = PH_HIGH;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        PH_HIGH: begin
          if ((cnt_q == '0) && !scl_in_i) begin
            cnt_d = cnt_q;                // line held low by a slave
          end else if (cnt_q == hi_q - ONE) begin
            phase_d = PH_LOW;
            cnt_d   = '0;
            cfg_ld  = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        default: begin
          phase_d = PH_OFF;
          cnt_d   = '0;
        end
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OFF;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // Per-period configuration capture, clock-enabled by cfg_ld
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= ONE;
      hi_q <= ONE;
    end else if (cfg_ld) begin
      lo_q <= lo_len_i;
      hi_q <= hi_len_i;
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
  assign lo_q_o  = lo_q;

  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW) |-> (cnt_q < lo_q)); // R3
  AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HIGH) |-> (cnt_q < hi_q)); // R4
  AST_STRETCH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rst_i && phase_q == PH_HIGH && cnt_q == '0 && !scl_in_i)
      |=> (phase_q == PH_HIGH && cnt_q == '0)); // R5
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW && $past(phase_q) == PH_LOW) |-> ($stable(lo_q) && $stable(hi_q))); // R8
endmodule

// File: rtl/scl_strobe_gen.sv
module scl_strobe_gen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  scl_phase_e       phase_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] lo_q_i,
  input  logic             scl_in_i,
  output logic             scl_low_o,
  output logic             chg_stb_o,
  output logic             smp_stb_o
);
  logic [CNT_W-1:0] mid_cnt;

  always_comb begin
    mid_cnt   = lo_q_i >> 1;
    scl_low_o = (phase_i == PH_LOW);
    chg_stb_o = (phase_i == PH_LOW) && (cnt_i == mid_cnt);
    smp_stb_o = (phase_i == PH_HIGH) && (cnt_i == '0) && scl_in_i;
  end

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(chg_stb_o && smp_stb_o)); // R6
  AST_CHG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    chg_stb_o |=> !chg_stb_o); // R6
  AST_SMP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb_o |=> !smp_stb_o); // R7
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_rst_i,
  input  logic [2*CNT_W-1:0] cfg_i,
  input  logic               scl_in_i,
  output logic               scl_low_o,
  output logic               chg_stb_o,
  output logic               smp_stb_o
);
  logic             rst_meta_n, rst_sync_n;
  logic [CNT_W-1:0] lo_len, hi_len, cnt, lo_q;
  scl_phase_e       phase;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  scl_cfg_decode #(.CNT_W(CNT_W)) i_decode (
    .cfg_i    (cfg_i),
    .lo_len_o (lo_len),
    .hi_len_o (hi_len)
  );

  scl_phase_ctr #(.CNT_W(CNT_W)) i_ctr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctl_rst_i (ctl_rst_i),
    .scl_in_i  (scl_in_i),
    .lo_len_i  (lo_len),
    .hi_len_i  (hi_len),
    .phase_o   (phase),
    .cnt_o     (cnt),
    .lo_q_o    (lo_q)
  );

  scl_strobe_gen #(.CNT_W(CNT_W)) i_strobe (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .phase_i   (phase),
    .cnt_i     (cnt),
    .lo_q_i    (lo_q),
    .scl_in_i  (scl_in_i),
    .scl_low_o (scl_low_o),
    .chg_stb_o (chg_stb_o),
    .smp_stb_o (smp_stb_o)
  );

  AST_IDLE_IN_RST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctl_rst_i |=> (!scl_low_o && !chg_stb_o && !smp_stb_o)); // R2
  AST_LOW_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(ctl_rst_i) && !ctl_rst_i) |=> scl_low_o); // R3
endmodule

// File: tb/test_scl_period_gen.sv
`timescale 1ns/1ps
module test_scl_period_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_rst;
  logic [31:0] cfg;
  logic        stretch;
  logic        scl_low, chg, smp;
  logic        scl_in;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;

  always #4 clk = ~clk;

  // Wire model: released line reads high unless a slave stretches it
  assign scl_in = !scl_low && !stretch;

  scl_period_gen i_scl_period_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_rst_i (ctl_rst),
    .cfg_i     (cfg),
    .scl_in_i  (scl_in),
    .scl_low_o (scl_low),
    .chg_stb_o (chg),
    .smp_stb_o (smp)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int lo_eff(int lo);
    return (lo == 0) ? 1 : lo;
  endfunction

  function automatic int hi_eff(int lo, int per);
    return (per > lo_eff(lo)) ? per - lo_eff(lo) : 1;
  endfunction

  // Expected {scl_low, chg, smp} t cycles after the first low cycle
  function automatic logic [2:0] exp_at(int lo, int per, int t);
    int l = lo_eff(lo);
    int p = t % (l + hi_eff(lo, per));
    return {p < l, p == l / 2, p == l};
  endfunction

  task automatic check_vec(input string req, input int t, input logic [2:0] exp);
    checks++;
    if ({scl_low, chg, smp} !== exp) begin
      errors++;
      $display("FAIL %s t=%0d actual=%b expected=%b", req, t, {scl_low, chg, smp}, exp);
    end
  endtask

  // Hold the controller in reset two cycles with a new config, then release.
  task automatic restart(input int lo, input int per);
    @(negedge clk);
    cfg = {lo[15:0], per[15:0]};
    ctl_rst = 1'b1;
    @(negedge clk); #1;
    check_vec("R2 idle in controller reset", -2, 3'b000);
    @(negedge clk); #1;
    check_vec("R2 counter held", -1, 3'b000);
    ctl_rst = 1'b0;
  endtask

  task automatic run_cfg(input int lo, input int per, input string req);
    int p = lo_eff(lo) + hi_eff(lo, per);
    restart(lo, per);
    for (int t = 0; t < 2 * p + 1; t++) begin
      @(negedge clk); #1;
      check_vec(req, t, exp_at(lo, per, t));
    end
  endtask

  initial begin
    rst_n   = 1'b0;
    ctl_rst = 1'b1;
    cfg     = '0;
    stretch = 1'b0;
    repeat (3) @(negedge clk);
    #1 check_vec("R2 under rst_n", -3, 3'b000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Exhaustive sweep over small low/period counts (R3 R4 R6 R7 R9)
    for (int lo = 0; lo <= 6; lo++) begin
      for (int per = 0; per <= 9; per++) begin
        if (lo == 0 || per <= lo_eff(lo))
          run_cfg(lo, per, "R9 clamp");
        else
          run_cfg(lo, per, "R3 R4 R6 R7 phase");
      end
    end

    // Field placement with a 5/9 duty (R1)
    run_cfg(20, 36, "R1 field split");
    run_cfg(300, 540, "R1 wide fields");

    // Stretch: low 3, period 7, slave holds SCL for 5 cycles (R5)
    begin
      int s = 5;
      restart(3, 7);
      for (int t = 0; t < 3 + s + 4 + 8; t++) begin
        @(negedge clk);
        stretch = (t < 3 + s);
        #1;
        if (t < 3)
          check_vec("R5 low before stretch", t, exp_at(3, 7, t));
        else if (t < 3 + s)
          check_vec("R5 stretched", t, 3'b000);
        else if (t - 3 - s < 4)
          check_vec("R5 R7 high after stretch", t, {1'b0, 1'b0, (t - 3 - s) == 0});
        else
          check_vec("R5 next period", t, exp_at(3, 7, t - 3 - s - 4));
      end
      stretch = 1'b0;
    end

    // Mid-period config write applies next period (R8)
    restart(2, 5);
    for (int t = 0; t < 5 + 13; t++) begin
      @(negedge clk);
      if (t == 1) cfg = {16'd4, 16'd6};
      #1;
      if (t < 5)
        check_vec("R8 old config", t, exp_at(2, 5, t));
      else
        check_vec("R8 new config", t, exp_at(4, 6, t - 5));
    end

    // Controller reset in the middle of a high phase (R2)
    restart(4, 10);
    for (int t = 0; t < 6; t++) begin
      @(negedge clk); #1;
      check_vec("R3 R4 before abort", t, exp_at(4, 10, t));
    end
    ctl_rst = 1'b1;
    @(negedge clk); #1;
    check_vec("R2 abort mid phase", 6, 3'b000);
    ctl_rst = 1'b0;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk); #1;
      check_vec("R3 restart from low", t, exp_at(4, 10, t));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule